// File: doc/BRIEF.md
# Dual Modulus Prescaler Divider

This block is a synchronous clock divider for the feedback path of a phase-locked loop. Every input clock cycle it advances a small phase machine. The output is one divided clock whose period is 8, 9, 16 or 17 input clocks. A static range-select input chooses between the short pair (8/9) and the long pair (16/17). A modulus-control input then chooses, one output period at a time, the lower member of the pair when high or the higher member when low. A synthesizer's swallow counter uses this to set the loop's overall division.

The core counts two half-periods of `N/2` clocks each, with the base `N` being 8 or 16. When the higher modulus is in force, one extra clock is swallowed at the end of the active half. The phase machine has three states:
- `PH_LEAD`: the active half. The output sits at its active level for `N/2` clocks.
- `PH_SWALLOW`: the optional extra clock. The output stays active.
- `PH_TRAIL`: the inactive half, lasting `N/2` clocks.

The machine moves through these transitions:
- LEAD-to-SWALLOW, taken at the last LEAD count when the higher modulus was sampled.
- LEAD-to-TRAIL, taken at the last LEAD count otherwise.
- SWALLOW-to-TRAIL, taken after one clock.
- TRAIL-to-LEAD, the period boundary.

Range select and modulus control are sampled only on the TRAIL-to-LEAD transition. A change made mid-period therefore never shortens or stretches the period in progress. The output is registered. A build-time parameter inverts it, so a downstream counter can trigger on either a rising or a falling edge.

Top module: `dmod_prescaler`

## Requirements
- R1: With range_sel=1 and mod_ctl=1 held, the spacing between successive active output edges is 8 input clocks.
- R2: With range_sel=1 and mod_ctl=0 held, the spacing is 9 input clocks.
- R3: With range_sel=0 and mod_ctl=1 held, the spacing is 16 input clocks.
- R4: With range_sel=0 and mod_ctl=0 held, the spacing is 17 input clocks.
- R5: In each period the output holds its active level for N/2 clocks, plus one more when the higher modulus applies (4, 5, 8 or 9 clocks). For the rest of the period it holds the inactive level.
- R6: A synchronous active-high rst forces the output to its inactive level on the next clock edge and holds it there while rst stays high. The inactive level is 0 when INVERT_OUT=0.
- R7: mod_ctl is sampled only at the clock edge that produces an active output edge. A change made inside a period leaves that period's length unchanged and takes effect in the next period, even when the change comes one clock before the boundary.
- R8: range_sel is sampled at the same boundary as mod_ctl. A mid-period change leaves the current period intact and sets the next one.
- R9: With INVERT_OUT=1 the output is the bitwise complement of the INVERT_OUT=0 output, so its active edge is the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 1 | 1 selects the 8/9 pair, 0 selects the 16/17 pair |
| mod_ctl | input | 1 | 1 selects the lower ratio of the pair, 0 the higher |
| div_out | output | 1 | Divided clock, polarity set by INVERT_OUT |

## Verification
The assertions assume that mod_ctl and range_sel are synchronous to clk and settled before the sampling edge. They also assume that rst is a clean synchronous level. Under these assumptions, the sampled configuration only changes at a period boundary, the swallow state lasts exactly one clock, and the output rises only just after a boundary. The stimulus drives every input on the falling clock edge, so each change is set up half a clock before the next rising edge. Changes to modulus and range are placed both mid-period and one clock before a boundary, which tests the sampling rule at both extremes.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    typedef enum logic [1:0] {
        PH_LEAD    = 2'd0,
        PH_SWALLOW = 2'd1,
        PH_TRAIL   = 2'd2
    } phase_e;

endpackage

// File: rtl/dmp_mod_sampler.sv
module dmp_mod_sampler (
    input  logic clk,
    input  logic rst,
    input  logic range_sel,
    input  logic mod_ctl,
    input  logic load,
    output logic range_small_q,
    output logic swallow_q
);

    // Configuration is captured at reset and at each period boundary only.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            range_small_q <= range_sel;
            swallow_q     <= ~mod_ctl;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(swallow_q) && $stable(range_small_q))); // R7

    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(range_small_q)); // R8

endmodule

// File: rtl/dmp_phase_fsm.sv
module dmp_phase_fsm
    import dmp_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] half_last,
    input  logic             swallow,
    output phase_e           phase_q,
    output phase_e           phase_n,
    output logic             period_end
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic             at_last;

    assign at_last = (cnt_q == half_last);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_TRAIL;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next-state logic
    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q + 1'b1;
        unique case (phase_q)
            PH_LEAD: begin
                if (at_last) begin
                    phase_n = swallow ? PH_SWALLOW : PH_TRAIL;
                    cnt_n   = '0;
                end
            end
            PH_SWALLOW: begin
                phase_n = PH_TRAIL;
                cnt_n   = '0;
            end
            PH_TRAIL: begin
                if (at_last) begin
                    phase_n = PH_LEAD;
                    cnt_n   = '0;
                end
            end
            default: begin
                phase_n = PH_TRAIL;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        period_end = (phase_q == PH_TRAIL) && at_last;
    end

    AST_SWALLOW_ONE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SWALLOW) |=> (phase_q == PH_TRAIL)); // R5

    AST_SWALLOW_GATED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SWALLOW) |-> swallow); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_SWALLOW) |-> (cnt_q <= half_last)); // R5

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end); // R7

endmodule

// File: rtl/dmp_out_stage.sv
module dmp_out_stage
    import dmp_pkg::*;
#(
    parameter bit INVERT_OUT = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_n,
    input  logic   period_end,
    output logic   div_out
);

    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= (phase_n != PH_TRAIL);
    end

    generate
        if (INVERT_OUT) begin : g_neg
            assign div_out = ~act_q;
        end else begin : g_pos
            assign div_out = act_q;
        end
    endgenerate

    AST_RESET_INACTIVE: assert property (@(posedge clk)
        rst |=> (act_q == 1'b0)); // R6

    AST_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past(period_end)); // R7

endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
    import dmp_pkg::*;
#(
    parameter int SMALL_DIV  = 8,
    parameter int LARGE_DIV  = 16,
    parameter bit INVERT_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic range_sel,
    input  logic mod_ctl,
    output logic div_out
);

    localparam int H_SMALL = SMALL_DIV / 2;
    localparam int H_LARGE = LARGE_DIV / 2;
    localparam int CNT_W   = (H_LARGE > 2) ? $clog2(H_LARGE) : 1;
    localparam logic [CNT_W-1:0] LAST_SMALL = CNT_W'(H_SMALL - 1);
    localparam logic [CNT_W-1:0] LAST_LARGE = CNT_W'(H_LARGE - 1);

    logic             range_small_q;
    logic             swallow_q;
    logic             period_end;
    logic [CNT_W-1:0] half_last;
    phase_e           phase_q;
    phase_e           phase_n;

    assign half_last = range_small_q ? LAST_SMALL : LAST_LARGE;

    dmp_mod_sampler u_sampler (
        .clk           (clk),
        .rst           (rst),
        .range_sel     (range_sel),
        .mod_ctl       (mod_ctl),
        .load          (period_end),
        .range_small_q (range_small_q),
        .swallow_q     (swallow_q)
    );

    dmp_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .half_last  (half_last),
        .swallow    (swallow_q),
        .phase_q    (phase_q),
        .phase_n    (phase_n),
        .period_end (period_end)
    );

    dmp_out_stage #(.INVERT_OUT(INVERT_OUT)) u_out (
        .clk        (clk),
        .rst        (rst),
        .phase_n    (phase_n),
        .period_end (period_end),
        .div_out    (div_out)
    );

    initial begin
        AST_PARAM_EVEN: assert ((SMALL_DIV % 2 == 0) && (LARGE_DIV % 2 == 0)
                                && (SMALL_DIV >= 2) && (LARGE_DIV >= SMALL_DIV)); // R1
    end

endmodule

// File: tb/dmod_prescaler_test.sv
module dmod_prescaler_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic range_sel = 1'b1;
    logic mod_ctl = 1'b1;
    logic op;
    logic oi;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int edge_cyc = 0;
    int edge_count = 0;
    int inv_fall = 0;
    int inv_bad = 0;
    int last_period = 0;
    int last_high = 0;
    bit have_edge = 0;
    logic op_prev = 1'b0;
    logic oi_prev = 1'b1;

    always #10 clk = ~clk;

    dmod_prescaler #(.INVERT_OUT(1'b0)) uut (
        .clk(clk), .rst(rst), .range_sel(range_sel), .mod_ctl(mod_ctl), .div_out(op)
    );

    dmod_prescaler #(.INVERT_OUT(1'b1)) uut_inv (
        .clk(clk), .rst(rst), .range_sel(range_sel), .mod_ctl(mod_ctl), .div_out(oi)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (op && !op_prev) begin
                if (have_edge) last_period = cyc - edge_cyc;
                edge_cyc   = cyc;
                have_edge  = 1;
                edge_count = edge_count + 1;
            end
            if (!op && op_prev && have_edge) last_high = cyc - edge_cyc;
        end else begin
            have_edge = 0;
        end
        if (!oi && oi_prev) inv_fall = inv_fall + 1;
        if (oi !== ~op) inv_bad = inv_bad + 1;
        op_prev = op;
        oi_prev = oi;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int k);
        int target;
        target = edge_count + k;
        wait (edge_count >= target);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R6 reset level", int'(op), 0);
        check("R9 reset level inverted", int'(oi), 1);
        rst = 1'b0;

        // Sweep every range/modulus combination.
        for (int r = 1; r >= 0; r--) begin
            for (int m = 1; m >= 0; m--) begin
                int n_exp;
                int h_exp;
                string tag;
                range_sel = r[0];
                mod_ctl   = m[0];
                n_exp = (r == 1 ? 8 : 16) + (m == 1 ? 0 : 1);
                h_exp = (r == 1 ? 4 : 8) + (m == 1 ? 0 : 1);
                tag = (r == 1) ? ((m == 1) ? "R1" : "R2") : ((m == 1) ? "R3" : "R4");
                wait_edges(2);
                check(tag, last_period, n_exp);
                check("R5 active phase", last_high, h_exp);
                wait_edges(1);
                check(tag, last_period, n_exp);
                check("R5 active phase", last_high, h_exp);
            end
        end

        // Modulus change mid-period, then one clock before the boundary.
        range_sel = 1'b1;
        mod_ctl   = 1'b1;
        wait_edges(2);
        wait_edges(1);
        repeat (3) @(negedge clk);
        mod_ctl = 1'b0;
        wait_edges(1);
        check("R7 mid-period change ignored", last_period, 8);
        wait_edges(1);
        check("R7 change applies next period", last_period, 9);
        wait_edges(1);
        repeat (8) @(negedge clk);
        mod_ctl = 1'b1;
        wait_edges(1);
        check("R7 late change ignored", last_period, 9);
        wait_edges(1);
        check("R7 late change applies", last_period, 8);

        // Range change mid-period.
        wait_edges(1);
        repeat (2) @(negedge clk);
        range_sel = 1'b0;
        wait_edges(1);
        check("R8 range change ignored", last_period, 8);
        wait_edges(1);
        check("R8 range change applies", last_period, 16);

        // Reset in the middle of a period.
        wait_edges(1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 mid-period reset level", int'(op), 0);
        check("R9 mid-period reset inverted", int'(oi), 1);
        rst = 1'b0;
        wait_edges(3);
        check("R6 period after reset", last_period, 16);

        @(negedge clk);
        check("R9 complement mismatches", inv_bad, 0);
        check("R9 falling edge count", inv_fall, edge_count);
        finish_run();
    end

endmodule